// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor

This block watches a recovered bipolar data stream, delivered as a positive-mark flag and a negative-mark flag per bit slot, qualified by a bit-slot enable. It counts consecutive empty slots and raises a loss-of-signal flag once the run grows past a limit that depends on the selected line mode. The run limit is 32 slots for the 2048 kbit/s and 64 kbit/s modes and 175 slots for the 1544 kbit/s mode.

Once raised, the flag does not drop on a single mark. It drops only when the most recent 32 slots carry at least four marks (12.5 % density) and an external amplitude-good input is high. The recovered marks are also passed to two registered data outputs. These outputs can be forced low by a mute input, which may be tied to the loss flag, and can be presented active-low by an invert input.

Top module: `los_monitor`

## Requirements
- R1: During and right after reset, `los` is 1, `dat_p` and `dat_n` are 0, and the zero-run count is zero.
- R2: A zero is a slot with `bit_en` high and both `mark_p` and `mark_n` low. A slot with both marks high counts as one mark. Clock cycles with `bit_en` low change neither the zero run, the density window nor `los`, whatever the mark inputs hold.
- R3: With `mode` 2'b00 (2048 kbit/s) or 2'b01 (64 kbit/s), `los` rises in the cycle after the 33rd consecutive zero. It stays low after 32 consecutive zeros.
- R4: With `mode` 2'b10 or 2'b11 (1544 kbit/s), `los` rises in the cycle after the 176th consecutive zero. It stays low after 175.
- R5: Any mark resets the zero run to zero, so a run that is broken by a mark must start over.
- R6: While `los` is high, it clears in the cycle after a slot at which the last 32 slots, including that slot, hold at least 4 marks and `lvl_ok` is high. Three marks are not enough.
- R7: While `lvl_ok` is low, `los` stays high regardless of mark density.
- R8: When `mute` is high at a slot, `dat_p` and `dat_n` are both 0 in the next cycle, whatever the setting of `invert`.
- R9: Without mute, each slot updates `dat_p`/`dat_n` in the next cycle to `mark_p`/`mark_n`, or to their complements when `invert` is high.
- R10: The density window slides. A mark older than 32 slots no longer counts toward clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks a valid bit slot |
| mark_p | input | 1 | Positive mark in this slot |
| mark_n | input | 1 | Negative mark in this slot |
| mode | input | 2 | 00 = 2048k, 01 = 64k, 1x = 1544k |
| lvl_ok | input | 1 | External amplitude-good indication |
| mute | input | 1 | Force data outputs low |
| invert | input | 1 | Present data outputs active-low |
| dat_p | output | 1 | Registered positive data |
| dat_n | output | 1 | Registered negative data |
| los | output | 1 | Loss-of-signal flag |

## Verification
Zero runs of exactly the limit and one past it are sent in each mode. These separate an off-by-one in the declare point from a wrong per-mode limit. A run broken by a single mark, and a run padded with enable-low cycles that carry marks, show whether the counter restarts on a mark and ignores non-slots. For the clear path, the bench sends three and then four marks, sends marks with the amplitude input low, and sends two marks that are left to age out of the window before new ones arrive. These patterns tell a real sliding 32-slot density count apart from a cumulative count or a single-mark clear. Output patterns cover plain, inverted and muted data.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic [1:0] {
    LM_E1  = 2'b00,
    LM_K64 = 2'b01,
    LM_T1  = 2'b10,
    LM_T1X = 2'b11
  } line_mode_t;

  // Number of consecutive zeros at which loss is declared (limit + 1).
  function automatic int declare_count(line_mode_t m, int e1_run, int t1_run);
    if (m == LM_T1 || m == LM_T1X) return t1_run + 1;
    return e1_run + 1;
  endfunction

  // Running window count after shifting in one flag and dropping one.
  function automatic int window_next(int cur, logic in_b, logic out_b);
    return cur + int'(in_b) - int'(out_b);
  endfunction

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
  parameter int E1_RUN = 32,
  parameter int T1_RUN = 175,
  parameter int RUN_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 is_mark,
  input  los_pkg::line_mode_t  mode,
  output logic                 decl_o
);
  localparam int MAX_CNT = (E1_RUN > T1_RUN ? E1_RUN : T1_RUN) + 1;

  logic [RUN_W-1:0] run;
  int               lim;
  logic             zero_slot;

  always_comb begin
    lim       = los_pkg::declare_count(mode, E1_RUN, T1_RUN);
    zero_slot = bit_en && !is_mark;
    decl_o    = zero_slot && ((int'(run) + 1) >= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0;
    end else if (bit_en) begin
      if (is_mark)                run <= '0;
      else if (int'(run) < lim)   run <= run + 1'b1;
    end
  end

  a_r5_mark_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && is_mark) |=> (run == '0));
  a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run) <= MAX_CNT);
  a_r2_idle_run_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(run));

endmodule

// File: rtl/los_density_win.sv
module los_density_win #(
  parameter int WIN_LEN   = 32,
  parameter int MIN_MARKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic is_mark,
  output logic dense_o
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic [WIN_LEN-1:0] win;
  logic [CNT_W-1:0]   cnt;
  int                 cnt_nx;

  always_comb begin
    cnt_nx  = los_pkg::window_next(int'(cnt), is_mark, win[WIN_LEN-1]);
    dense_o = bit_en && (cnt_nx >= MIN_MARKS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= '0;
      cnt <= '0;
    end else if (bit_en) begin
      win <= {win[WIN_LEN-2:0], is_mark};
      cnt <= CNT_W'(cnt_nx);
    end
  end

  a_r10_count_tracks_window: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) == $countones(win));
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= WIN_LEN);

endmodule

// File: rtl/los_out_stage.sv
module los_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic mark_p,
  input  logic mark_n,
  input  logic mute,
  input  logic invert,
  output logic dat_p,
  output logic dat_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_p <= 1'b0;
      dat_n <= 1'b0;
    end else if (bit_en) begin
      dat_p <= mute ? 1'b0 : (mark_p ^ invert);
      dat_n <= mute ? 1'b0 : (mark_n ^ invert);
    end
  end

  a_r8_mute_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mute) |=> (!dat_p && !dat_n));
  a_r9_invert_complements: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !mute && invert) |=> (dat_p == !$past(mark_p) && dat_n == !$past(mark_n)));

endmodule

// File: rtl/los_monitor.sv
module los_monitor #(
  parameter int WIN_LEN   = 32,
  parameter int MIN_MARKS = 4,
  parameter int E1_RUN    = 32,
  parameter int T1_RUN    = 175
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       mark_p,
  input  logic       mark_n,
  input  logic [1:0] mode,
  input  logic       lvl_ok,
  input  logic       mute,
  input  logic       invert,
  output logic       dat_p,
  output logic       dat_n,
  output logic       los
);
  localparam int RUN_W = $clog2((E1_RUN > T1_RUN ? E1_RUN : T1_RUN) + 2);

  logic                is_mark;
  logic                decl_evt;
  logic                dense;
  logic                clr_evt;
  los_pkg::line_mode_t mode_e;

  assign is_mark = mark_p || mark_n;
  assign mode_e  = los_pkg::line_mode_t'(mode);
  assign clr_evt = dense && lvl_ok;

  los_zero_run #(.E1_RUN(E1_RUN), .T1_RUN(T1_RUN), .RUN_W(RUN_W)) u_run (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .is_mark(is_mark),
    .mode(mode_e), .decl_o(decl_evt));

  los_density_win #(.WIN_LEN(WIN_LEN), .MIN_MARKS(MIN_MARKS)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .is_mark(is_mark),
    .dense_o(dense));

  los_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark_p(mark_p),
    .mark_n(mark_n), .mute(mute), .invert(invert),
    .dat_p(dat_p), .dat_n(dat_n));

  always_ff @(posedge clk) begin
    if (!rst_n)                los <= 1'b1;
    else if (los && clr_evt)   los <= 1'b0;
    else if (!los && decl_evt) los <= 1'b1;
  end

  a_r3_declare_sets_los: assert property (@(posedge clk) disable iff (!rst_n)
    (!los && decl_evt) |=> los);
  a_r6_clear_drops_los: assert property (@(posedge clk) disable iff (!rst_n)
    (los && clr_evt) |=> !los);
  a_r7_level_holds_los: assert property (@(posedge clk) disable iff (!rst_n)
    (los && !lvl_ok) |=> los);
  a_r2_idle_holds_los: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(los));
  a_r5_mark_never_declares: assert property (@(posedge clk) disable iff (!rst_n)
    (!los && bit_en && is_mark) |=> !los);

endmodule

// File: tb/sim_los_monitor.sv
module sim_los_monitor;
  logic       clk = 1'b0;
  logic       rst_n, bit_en, mark_p, mark_n, lvl_ok, mute, invert;
  logic [1:0] mode;
  logic       dat_p, dat_n, los;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  los_monitor u0 (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark_p(mark_p),
    .mark_n(mark_n), .mode(mode), .lvl_ok(lvl_ok), .mute(mute),
    .invert(invert), .dat_p(dat_p), .dat_n(dat_n), .los(los));

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic slot(logic p, logic n);
    bit_en = 1'b1; mark_p = p; mark_n = n;
    @(posedge clk); #1;
  endtask

  task automatic idle(logic p, logic n);
    bit_en = 1'b0; mark_p = p; mark_n = n;
    @(posedge clk); #1;
  endtask

  task automatic zeros(int k);
    for (int i = 0; i < k; i++) slot(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bit_en = 0; mark_p = 0; mark_n = 0;
    mode = 2'b00; lvl_ok = 1; mute = 0; invert = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 los at reset", los, 1'b1);
    chk("R1 dat_p at reset", dat_p, 1'b0);
    chk("R1 dat_n at reset", dat_n, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_clear_min();
    for (int i = 0; i < 3; i++) slot(1'b1, 1'b0);
    chk("R6 three marks keep los", los, 1'b1);
    slot(1'b0, 1'b1);
    chk("R6 fourth mark clears los", los, 1'b0);
  endtask

  task automatic t_declare_e1_idle();
    mode = 2'b00;
    slot(1'b1, 1'b1);
    chk("R2 double mark keeps los low", los, 1'b0);
    zeros(16);
    for (int i = 0; i < 5; i++) idle(1'b1, 1'b0);
    zeros(16);
    chk("R3 32 zeros no loss", los, 1'b0);
    chk("R2 idle marks ignored", los, 1'b0);
    idle(1'b1, 1'b1);
    chk("R2 idle slot does not declare", los, 1'b0);
    zeros(1);
    chk("R3 33rd zero declares", los, 1'b1);
  endtask

  task automatic t_level_gate();
    lvl_ok = 1'b0;
    for (int i = 0; i < 8; i++) slot(1'b1, 1'b0);
    chk("R7 low level blocks clear", los, 1'b1);
    lvl_ok = 1'b1;
    slot(1'b1, 1'b0);
    chk("R7 clear once level ok", los, 1'b0);
  endtask

  task automatic t_run_restart();
    mode = 2'b01;
    zeros(32);
    slot(1'b1, 1'b0);
    zeros(32);
    chk("R5 broken run no loss", los, 1'b0);
    zeros(1);
    chk("R3 64k 33rd zero declares", los, 1'b1);
    for (int i = 0; i < 4; i++) slot(1'b1, 1'b0);
    chk("R6 recover", los, 1'b0);
  endtask

  task automatic t_declare_t1();
    mode = 2'b10;
    zeros(33);
    chk("R4 T1 not declared at 33", los, 1'b0);
    zeros(142);
    chk("R4 T1 175 zeros no loss", los, 1'b0);
    zeros(1);
    chk("R4 T1 176th zero declares", los, 1'b1);
  endtask

  task automatic t_window_slide();
    slot(1'b1, 1'b0); slot(1'b1, 1'b0);
    zeros(30);
    slot(1'b1, 1'b0);
    chk("R10 aged marks drop, 3rd", los, 1'b1);
    slot(1'b1, 1'b0);
    chk("R10 aged marks drop, 4th", los, 1'b1);
    slot(1'b1, 1'b0);
    chk("R10 window three", los, 1'b1);
    slot(1'b1, 1'b0);
    chk("R10 window four clears", los, 1'b0);
  endtask

  task automatic t_outputs();
    mute = 0; invert = 0;
    slot(1'b1, 1'b0);
    chk("R9 plain dat_p", dat_p, 1'b1);
    chk("R9 plain dat_n", dat_n, 1'b0);
    invert = 1;
    slot(1'b1, 1'b0);
    chk("R9 invert dat_p", dat_p, 1'b0);
    chk("R9 invert dat_n", dat_n, 1'b1);
    slot(1'b0, 1'b0);
    chk("R9 invert idle dat_p", dat_p, 1'b1);
    mute = 1;
    slot(1'b0, 1'b0);
    chk("R8 mute+invert dat_p", dat_p, 1'b0);
    chk("R8 mute+invert dat_n", dat_n, 1'b0);
    invert = 0;
    slot(1'b1, 1'b1);
    chk("R8 mute dat_p", dat_p, 1'b0);
    chk("R8 mute dat_n", dat_n, 1'b0);
    mute = 0;
    slot(1'b0, 1'b1);
    chk("R9 unmuted dat_n", dat_n, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_clear_min();
    t_declare_e1_idle();
    t_level_gate();
    t_run_restart();
    t_declare_t1();
    t_window_slide();
    t_outputs();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule